// File: doc/BRIEF.md
# Hardware Trap Priority Controller

This block takes run-time exception requests from a small CPU core and turns them into branch requests. Each request is latched as pending. A source that can be traced also sets a sticky flag bit. On every cycle the block picks one pending request and issues a one-cycle branch. The branch carries a full vector address, a trap number and the priority the handler runs at.

Requests fall into three hardware classes. Reset sources are the highest. Class A sources (non-maskable interrupt, stack overflow, stack underflow, software break) are in the middle. Class B faults (undefined opcode, memory access error, protected instruction fault, illegal word operand access) are the lowest. A software trap instruction sits beside the three classes. It carries its own 7-bit number, keeps the current CPU priority and does not raise the trap level.

A small stack records the trap level being serviced. A return strobe pops it. While any trap level is active, the block holds off the single standard-interrupt request.

Top module: `trap_prio_ctrl`

## Requirements
- R1: A pulse on any bit of `rst_src_i` produces a branch with offset 0x0000, number 0x00 and `br_lvl_o` = 3. This happens even while level 3 is active. The branch sets the active level to 3, empties the nesting stack and discards pending class A, class B and software requests.
- R2: Class A bit i (0 NMI, 1 stack overflow, 2 stack underflow, 3 software break) branches with number 2*(i+1), offset number*4 and `br_lvl_o` = 2.
- R3: When several class A bits are pending, the lowest bit index is serviced first. The others stay pending until the level drops below 2.
- R4: Any class B bits pending together produce one branch with number 0x0A, offset 0x0028 and `br_lvl_o` = 1. No hardware branch ever carries a number other than 0x00, 0x02, 0x04, 0x06, 0x08 or 0x0A.
- R5: `flags_o` bits [3:0] follow class A bits [3:0], and bits [7:4] follow class B bits [3:0]. A request sets its bit. A one on `flag_clr_i` clears the bit, but a set in the same cycle wins. `rst_ni` clears all bits.
- R6: A hardware trap is taken only when its level is above the active level. Otherwise it waits. A taken trap makes `trap_lvl_o` equal to its level.
- R7: `irq_grant_o` follows `irq_pend_i` only while `trap_lvl_o` is 0.
- R8: A software trap with number n branches to offset n*4 with `br_lvl_o` = 0 and `br_prio_o` = `cpu_prio_i`, and leaves `trap_lvl_o` unchanged. A hardware trap that can be taken in the same cycle goes first.
- R9: `br_addr_o` is `vec_seg_i` placed above the 16-bit offset.
- R10: `trap_ret_i` restores the level that was active before the current trap. A return at level 0 leaves level 0.
- R11: Every hardware branch carries `br_prio_o` with all bits set.
- R12: A request present at clock edge k gives `br_valid_o` high for one cycle after edge k+1, if nothing blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_src_i | input | 3 | Reset-class requests (hardware, software, watchdog) |
| cls_a_i | input | 4 | Class A requests |
| cls_b_i | input | 4 | Class B requests |
| swt_req_i | input | 1 | Software trap instruction strobe |
| swt_num_i | input | SWT_W | Software trap number |
| cpu_prio_i | input | PRIO_W | Current CPU priority |
| vec_seg_i | input | SEG_W | Vector segment, upper address bits |
| irq_pend_i | input | 1 | Standard interrupt request pending |
| trap_ret_i | input | 1 | Return-from-trap strobe |
| flag_clr_i | input | 8 | Write-one-to-clear mask for the flags |
| br_valid_o | output | 1 | Branch request, one cycle |
| br_addr_o | output | SEG_W+16 | Full vector address |
| br_num_o | output | SWT_W | Trap number |
| br_lvl_o | output | 2 | New trap level (0 = software trap) |
| br_prio_o | output | PRIO_W | Priority the handler runs at |
| trap_lvl_o | output | 2 | Active trap level |
| flags_o | output | 8 | Sticky trap flags |
| irq_grant_o | output | 1 | Standard interrupt allowed through |

## Verification
Single pulses of each class show the vector and number map, the branch latency and that the segment is placed above the offset. Two class A bits raised together show the fixed order, and only the lower bit may branch first. Class B raised while a higher trap is active, then released by returns, shows that blocking and unwinding work and that one branch serves all class B bits. A class B fault raised with a software trap, a reset request at level 3, and a clear that lands on a set together show precedence, reset override and set-over-clear.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef logic [1:0] tlvl_t;
   localparam tlvl_t LVL_NONE = 2'd0;
   localparam tlvl_t LVL_I    = 2'd1;
   localparam tlvl_t LVL_II   = 2'd2;
   localparam tlvl_t LVL_III  = 2'd3;
   localparam int N_A = 4;
   localparam int N_B = 4;
   localparam int N_RST = 3;
   localparam int FLAG_W = N_A + N_B;
   localparam int OFS_W = 16;
endpackage

// File: rtl/trap_flag_reg.sv
module trap_flag_reg #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       q_o[i] <= 1'b0;
         else if (set_i[i]) q_o[i] <= 1'b1;
         else if (clr_i[i]) q_o[i] <= 1'b0;
      end
      p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[i] |=> q_o[i]);
   end
endmodule

// File: rtl/trap_select.sv
module trap_select
   import trap_pkg::*;
#(
   parameter int SWT_W = 7
) (
   input  logic             pend_rst_i,
   input  logic [N_A-1:0]   pend_a_i,
   input  logic [N_B-1:0]   pend_b_i,
   input  logic             pend_sw_i,
   input  logic [SWT_W-1:0] sw_num_i,
   input  tlvl_t            act_lvl_i,
   output logic             take_hw_o,
   output logic             take_rst_o,
   output logic             take_sw_o,
   output logic [SWT_W-1:0] sel_num_o,
   output tlvl_t            sel_lvl_o,
   output logic [N_A-1:0]   clr_a_o,
   output logic             clr_b_o
);
   localparam logic [SWT_W-1:0] NUM_RST = '0;
   localparam logic [SWT_W-1:0] NUM_B   = SWT_W'(10);

   always_comb begin
      take_hw_o  = 1'b0;
      take_rst_o = 1'b0;
      take_sw_o  = 1'b0;
      sel_num_o  = '0;
      sel_lvl_o  = LVL_NONE;
      clr_a_o    = '0;
      clr_b_o    = 1'b0;
      if (pend_rst_i) begin
         take_hw_o  = 1'b1;
         take_rst_o = 1'b1;
         sel_lvl_o  = LVL_III;
         sel_num_o  = NUM_RST;
      end else if (|pend_a_i && act_lvl_i < LVL_II) begin
         take_hw_o = 1'b1;
         sel_lvl_o = LVL_II;
         for (int i = N_A - 1; i >= 0; i--) begin
            if (pend_a_i[i]) begin
               clr_a_o    = '0;
               clr_a_o[i] = 1'b1;
               sel_num_o  = SWT_W'(2 * (i + 1));
            end
         end
      end else if (|pend_b_i && act_lvl_i < LVL_I) begin
         take_hw_o = 1'b1;
         sel_lvl_o = LVL_I;
         sel_num_o = NUM_B;
         clr_b_o   = 1'b1;
      end else if (pend_sw_i) begin
         take_sw_o = 1'b1;
         sel_num_o = sw_num_i;
      end
   end
endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack
   import trap_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  push_i,
   input  logic  flush_i,
   input  logic  pop_i,
   input  tlvl_t new_i,
   output tlvl_t act_o
);
   tlvl_t stk [DEPTH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                act_o <= LVL_NONE;
      else if (flush_i || push_i) act_o <= new_i;
      else if (pop_i)             act_o <= stk[0];
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      tlvl_t from_below, from_above;
      if (i == 0) begin : g_top
         assign from_below = act_o;
      end else begin : g_mid
         assign from_below = stk[i-1];
      end
      if (i == DEPTH - 1) begin : g_last
         assign from_above = LVL_NONE;
      end else begin : g_inner
         assign from_above = stk[i+1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      stk[i] <= LVL_NONE;
         else if (flush_i) stk[i] <= LVL_NONE;
         else if (push_i)  stk[i] <= from_below;
         else if (pop_i)   stk[i] <= from_above;
      end
   end

   p_push_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i || flush_i) |=> act_o == $past(new_i));
endmodule

// File: rtl/trap_prio_ctrl.sv
module trap_prio_ctrl
   import trap_pkg::*;
#(
   parameter int SEG_W   = 8,
   parameter int PRIO_W  = 4,
   parameter int SWT_W   = 7,
   parameter int NEST_D  = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [N_RST-1:0]       rst_src_i,
   input  logic [N_A-1:0]         cls_a_i,
   input  logic [N_B-1:0]         cls_b_i,
   input  logic                   swt_req_i,
   input  logic [SWT_W-1:0]       swt_num_i,
   input  logic [PRIO_W-1:0]      cpu_prio_i,
   input  logic [SEG_W-1:0]       vec_seg_i,
   input  logic                   irq_pend_i,
   input  logic                   trap_ret_i,
   input  logic [FLAG_W-1:0]      flag_clr_i,
   output logic                   br_valid_o,
   output logic [SEG_W+OFS_W-1:0] br_addr_o,
   output logic [SWT_W-1:0]       br_num_o,
   output logic [1:0]             br_lvl_o,
   output logic [PRIO_W-1:0]      br_prio_o,
   output logic [1:0]             trap_lvl_o,
   output logic [FLAG_W-1:0]      flags_o,
   output logic                   irq_grant_o
);
   localparam int PAD_W = OFS_W - SWT_W - 2;

   if (NEST_D < 3) begin : g_chk_depth
      $error("NEST_D must cover three strictly rising trap levels");
   end
   if (PAD_W < 0) begin : g_chk_num
      $error("SWT_W too wide for a 16-bit vector offset");
   end
   if (SWT_W < 4) begin : g_chk_numw
      $error("SWT_W must hold the class B trap number");
   end

   logic             pend_rst, pend_sw;
   logic [N_A-1:0]   pend_a, clr_a;
   logic [N_B-1:0]   pend_b;
   logic [SWT_W-1:0] sw_num, sel_num;
   logic             take_hw, take_rst, take_sw, clr_b;
   tlvl_t            sel_lvl, act_lvl;
   logic [OFS_W-1:0] sel_ofs;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_rst <= 1'b0;
         pend_a   <= '0;
         pend_b   <= '0;
         pend_sw  <= 1'b0;
         sw_num   <= '0;
      end else begin
         pend_rst <= |rst_src_i;
         pend_a   <= (take_rst ? '0 : (pend_a & ~clr_a)) | cls_a_i;
         pend_b   <= ((take_rst || clr_b) ? '0 : pend_b) | cls_b_i;
         pend_sw  <= swt_req_i | (pend_sw & ~take_sw & ~take_rst);
         if (swt_req_i) sw_num <= swt_num_i;
      end
   end

   trap_select #(.SWT_W(SWT_W)) u_sel (
      .pend_rst_i (pend_rst),
      .pend_a_i   (pend_a),
      .pend_b_i   (pend_b),
      .pend_sw_i  (pend_sw),
      .sw_num_i   (sw_num),
      .act_lvl_i  (act_lvl),
      .take_hw_o  (take_hw),
      .take_rst_o (take_rst),
      .take_sw_o  (take_sw),
      .sel_num_o  (sel_num),
      .sel_lvl_o  (sel_lvl),
      .clr_a_o    (clr_a),
      .clr_b_o    (clr_b)
   );

   trap_level_stack #(.DEPTH(NEST_D)) u_stk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (take_hw & ~take_rst),
      .flush_i (take_rst),
      .pop_i   (trap_ret_i & ~take_hw),
      .new_i   (sel_lvl),
      .act_o   (act_lvl)
   );

   trap_flag_reg #(.W(FLAG_W)) u_flg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  ({cls_b_i, cls_a_i}),
      .clr_i  (flag_clr_i),
      .q_o    (flags_o)
   );

   if (PAD_W > 0) begin : g_pad
      assign sel_ofs = {{PAD_W{1'b0}}, sel_num, 2'b00};
   end else begin : g_nopad
      assign sel_ofs = {sel_num, 2'b00};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         br_valid_o <= 1'b0;
         br_addr_o  <= '0;
         br_num_o   <= '0;
         br_lvl_o   <= LVL_NONE;
         br_prio_o  <= '0;
      end else begin
         br_valid_o <= take_hw | take_sw;
         br_addr_o  <= {vec_seg_i, sel_ofs};
         br_num_o   <= sel_num;
         br_lvl_o   <= take_sw ? LVL_NONE : sel_lvl;
         br_prio_o  <= take_sw ? cpu_prio_i : {PRIO_W{1'b1}};
      end
   end

   assign trap_lvl_o  = act_lvl;
   assign irq_grant_o = irq_pend_i & (act_lvl == LVL_NONE);

   p_hw_num_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_o && br_lvl_o != LVL_NONE) |->
      (br_num_o == '0 || br_num_o == SWT_W'(2) || br_num_o == SWT_W'(4) ||
       br_num_o == SWT_W'(6) || br_num_o == SWT_W'(8) || br_num_o == SWT_W'(10)));

   p_rises_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_o && br_lvl_o != LVL_NONE && br_lvl_o != LVL_III) |->
      (br_lvl_o > $past(trap_lvl_o)));

   p_swt_keeps_lvl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_o && br_lvl_o == LVL_NONE) |-> (trap_lvl_o == $past(trap_lvl_o)));

   p_hw_prio_max_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_o && br_lvl_o != LVL_NONE) |-> (br_prio_o == {PRIO_W{1'b1}}));
endmodule

// File: tb/sim_trap_prio_ctrl.sv
module sim_trap_prio_ctrl;
   localparam int SEG_W = 8, PRIO_W = 4, SWT_W = 7;

   typedef struct packed {
      logic [SEG_W+15:0] addr;
      logic [SWT_W-1:0]  num;
      logic [1:0]        lvl;
      logic [PRIO_W-1:0] prio;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] rst_src = '0;
   logic [3:0] cls_a = '0, cls_b = '0;
   logic swt_req = 1'b0;
   logic [SWT_W-1:0] swt_num = '0;
   logic [PRIO_W-1:0] cpu_prio = 4'd3;
   logic [SEG_W-1:0] seg = 8'h5A;
   logic irq_pend = 1'b0, trap_ret = 1'b0;
   logic [7:0] flag_clr = '0;
   logic br_valid;
   logic [SEG_W+15:0] br_addr;
   logic [SWT_W-1:0] br_num;
   logic [1:0] br_lvl, trap_lvl;
   logic [PRIO_W-1:0] br_prio;
   logic [7:0] flags;
   logic irq_grant;

   int checks = 0, fails = 0;
   item_t expq[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   trap_prio_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n), .rst_src_i(rst_src), .cls_a_i(cls_a), .cls_b_i(cls_b),
      .swt_req_i(swt_req), .swt_num_i(swt_num), .cpu_prio_i(cpu_prio), .vec_seg_i(seg),
      .irq_pend_i(irq_pend), .trap_ret_i(trap_ret), .flag_clr_i(flag_clr),
      .br_valid_o(br_valid), .br_addr_o(br_addr), .br_num_o(br_num), .br_lvl_o(br_lvl),
      .br_prio_o(br_prio), .trap_lvl_o(trap_lvl), .flags_o(flags), .irq_grant_o(irq_grant));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic item_t mk(input logic [15:0] ofs, input int num, input int lvl, input logic [PRIO_W-1:0] pr);
      item_t it;
      it.addr = {seg, ofs};
      it.num  = SWT_W'(num);
      it.lvl  = 2'(lvl);
      it.prio = pr;
      return it;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && br_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R6 unexpected branch", {br_addr, br_num}, 0);
         end else begin
            item_t e, a;
            e = expq.pop_front();
            a = {br_addr, br_num, br_lvl, br_prio};
            chk(a == e, "R1/R2/R3/R4/R8/R9/R11 branch item", 64'(a), 64'(e));
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [2:0] rs, input logic [3:0] a, input logic [3:0] b,
                        input bit sw, input logic [SWT_W-1:0] n, input logic [7:0] clr);
      @(negedge clk);
      rst_src = rs; cls_a = a; cls_b = b; swt_req = sw; swt_num = n; flag_clr = clr;
      @(negedge clk);
      rst_src = '0; cls_a = '0; cls_b = '0; swt_req = 1'b0; flag_clr = '0;
   endtask

   task automatic ret();
      @(negedge clk); trap_ret = 1'b1;
      @(negedge clk); trap_ret = 1'b0;
      idle(3);
   endtask

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               chk(1'b0, "watchdog", 0, 1);
               $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
               $finish;
            end
         end
      join_none

      idle(3);
      rst_n = 1'b1;
      irq_pend = 1'b1;
      idle(1);
      chk(br_valid == 1'b0, "R12 reset no branch", br_valid, 0);
      chk(trap_lvl == 2'd0, "R6 reset level", trap_lvl, 0);
      chk(flags == 8'h00, "R5 reset flags", flags, 0);
      chk(irq_grant == 1'b1, "R7 grant at level 0", irq_grant, 1);

      // R2, R12: NMI, latency exact
      expq.push_back(mk(16'h0008, 2, 2, 4'hF));
      pulse(0, 4'b0001, 0, 0, 0, 0);
      @(negedge clk);
      chk(br_valid == 1'b1, "R12 latency", br_valid, 1);
      idle(2);
      chk(trap_lvl == 2'd2, "R6 level after NMI", trap_lvl, 2);
      chk(irq_grant == 1'b0, "R7 grant held off", irq_grant, 0);
      chk(flags == 8'h01, "R5 NMI flag", flags, 8'h01);

      // R6: class B blocked at level 2, then released by return
      pulse(0, 0, 4'b0001, 0, 0, 0);
      idle(3);
      chk(flags == 8'h11, "R5 class B flag", flags, 8'h11);
      expq.push_back(mk(16'h0028, 10, 1, 4'hF));
      ret();
      chk(trap_lvl == 2'd1, "R10 R6 level after return and B", trap_lvl, 1);

      // R5: W1C and set-over-clear
      pulse(0, 0, 0, 0, 0, 8'h01);
      idle(1);
      chk(flags == 8'h10, "R5 write-one-to-clear", flags, 8'h10);
      pulse(0, 0, 4'b0100, 0, 0, 8'h40);
      idle(2);
      chk(flags == 8'h50, "R5 set wins over clear", flags, 8'h50);

      // R3: two class A at once, lower index first
      expq.push_back(mk(16'h0010, 4, 2, 4'hF));
      pulse(0, 4'b0110, 0, 0, 0, 0);
      idle(3);
      chk(trap_lvl == 2'd2, "R3 level", trap_lvl, 2);
      chk(expq.size() == 0, "R3 single branch", expq.size(), 0);
      expq.push_back(mk(16'h0018, 6, 2, 4'hF));
      ret();
      ret();
      chk(trap_lvl == 2'd1, "R10 nested unwind", trap_lvl, 1);
      expq.push_back(mk(16'h0028, 10, 1, 4'hF));
      ret();
      ret();
      chk(trap_lvl == 2'd0, "R10 back to zero", trap_lvl, 0);

      // R8: software trap, top number
      expq.push_back(mk(16'h01FC, 7'h7F, 0, 4'd3));
      pulse(0, 0, 0, 1, 7'h7F, 0);
      idle(3);
      chk(trap_lvl == 2'd0, "R8 level unchanged", trap_lvl, 0);

      // R9: different segment
      seg = 8'hA5;
      expq.push_back(mk(16'h0000, 0, 0, 4'd3));
      pulse(0, 0, 0, 1, 7'h00, 0);
      idle(3);
      seg = 8'h5A;

      // R1: reset source over active trap, and at level 3
      expq.push_back(mk(16'h0020, 8, 2, 4'hF));
      pulse(0, 4'b1000, 0, 0, 0, 0);
      idle(3);
      expq.push_back(mk(16'h0000, 0, 3, 4'hF));
      pulse(3'b010, 0, 0, 0, 0, 0);
      idle(3);
      chk(trap_lvl == 2'd3, "R1 level III", trap_lvl, 3);
      expq.push_back(mk(16'h0000, 0, 3, 4'hF));
      pulse(3'b100, 0, 0, 0, 0, 0);
      idle(3);
      pulse(0, 4'b0001, 0, 0, 0, 0);
      idle(3);
      chk(expq.size() == 0, "R6 NMI blocked at III", expq.size(), 0);
      expq.push_back(mk(16'h0008, 2, 2, 4'hF));
      ret();
      chk(trap_lvl == 2'd2, "R1 stack flushed", trap_lvl, 2);
      ret();
      chk(trap_lvl == 2'd0, "R10 after flush", trap_lvl, 0);

      // R8: hardware first, then the software trap
      expq.push_back(mk(16'h0028, 10, 1, 4'hF));
      expq.push_back(mk(16'h0014, 5, 0, 4'd3));
      pulse(0, 0, 4'b1000, 1, 7'h05, 0);
      idle(4);
      chk(trap_lvl == 2'd1, "R8 sw kept level", trap_lvl, 1);
      ret();
      ret();
      chk(trap_lvl == 2'd0, "R10 empty pop", trap_lvl, 0);
      chk(expq.size() == 0, "R4 all items seen", expq.size(), 0);

      // R5: reset clears flags
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk(flags == 8'h00, "R5 rst clears flags", flags, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule